// File: doc/BRIEF.md
# Multi-Sensor Three-Wire Serial Bridge

This block sits on a simple synchronous register bus and lets a processor bit-bang a small group of three-wire serial temperature sensors by software. Each sensor has its own chip-enable (reset) line. All sensors share one serial clock line and one write-data line. Every sensor returns its own read-data line. The processor toggles the lines one register write at a time and samples the sensors' outputs through a read register that packs one bit per sensor.

There are three registers. The control register carries the per-sensor enables and the shared clock level. The data-out register carries the level placed on the shared data line. The data-in register returns the synchronized data outputs of all sensors in parallel. The shared data line has an output enable. The bridge drives the line only when software has supplied a data bit and at least one sensor is enabled. Otherwise it releases the line so that an enabled sensor can drive its reply.

Top module: `tsense_bridge`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every sensor enable is low, the shared clock is high, the data-out level is low and the data line is released (output enable low).
- R2: A write to address 0 sets sensor enable i to bit i of the write data, for i below NUM_SENSORS. The pin changes at the rising edge that accepts the write.
- R3: Bit 4 of a write to address 0 sets the shared clock pin at the same edge. The clock pin holds its level at every edge that carries no write to address 0.
- R4: Write-data bits from NUM_SENSORS up to 3 have no effect on any pin. For example, with three sensors, a write of 0x08 to address 0 disables every sensor.
- R5: A write to address 1 sets the shared data-out pin to bit 0 of the write data and ignores all other bits.
- R6: A write to address 1 marks a data bit as pending. A write to address 0 that leaves every sensor disabled clears the pending mark. The output enable is high exactly when a data bit is pending and at least one sensor is enabled.
- R7: While address 2 is presented with write enable low, read data bit i, one edge later, is the synchronized data output of sensor i. All read-data bits at and above NUM_SENSORS are zero.
- R8: A sensor data input passes through two flip-flops before the read register. A level change is visible on the read data after the third rising edge and not after the second.
- R9: Presenting address 0 or 1 for reading returns zero and changes no pin. A write to address 2 changes no pin.
- R10: A write to any address other than 0, 1 and 2 changes no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sns_en_o | output | NUM_SENSORS | Per-sensor enable (reset) lines, high = enabled |
| sns_clk_o | output | 1 | Shared serial clock |
| sns_dq_o | output | 1 | Level driven on the shared data line |
| sns_dq_oe | output | 1 | Output enable for the shared data line |
| sns_dq_i | input | NUM_SENSORS | Data output of each sensor |

## Verification
The bench targets the output-enable rule. It disables every sensor with a write that only sets an enable bit above the sensor count, then re-enables the sensors. A design that cleared the pending mark on the wrong bits would keep driving the line or would start driving it again. A design that decoded the clock from the wrong bit, or let a data write touch the clock, would show a clock pin that moves out of step with the table. The read path is sampled edge by edge after an input change. A design with one synchronizer stage too few would show the new value one edge early. A design that leaked bits into the upper read field, or answered reads of the write-only registers, would return a non-zero value there.

// File: rtl/tsb_pkg.sv
// Package: register map and bit positions shared by the bridge modules.
// Assumes: address decoding compares full bus_addr against these values.
package tsb_pkg;
    localparam int unsigned ADR_CTRL   = 0;  // enables + shared clock
    localparam int unsigned ADR_DOUT   = 1;  // shared data-out level
    localparam int unsigned ADR_DIN    = 2;  // packed sensor data-in
    localparam int unsigned CLK_BIT    = 4;  // clock bit inside control word
    localparam int unsigned MAX_SENSORS = 4;
endpackage

// File: rtl/tsb_sync.sv
// Module: tsb_sync
// Two-flop synchronizer, one independent chain per sensor input.
// Assumes: inputs are quasi-static levels; no reset so first two samples
// after power-up may be unknown.
module tsb_sync #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_chain
        logic stage1;
        logic stage2;
        // Purpose: two-stage capture of one sensor line.
        always_ff @(posedge clk) begin
            stage1 <= async_i[g];
            stage2 <= stage1;
        end
        assign sync_o[g] = stage2;
    end
endmodule

// File: rtl/tsb_ctrl_regs.sv
// Module: tsb_ctrl_regs
// Holds the pin-side registers: sensor enables, shared clock, data-out
// level and the pending flag that gates the data-line output enable.
// Assumes: wr_ctrl and wr_dout are never high together (one address).
module tsb_ctrl_regs #(
    parameter int unsigned NUM_SENSORS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_ctrl,
    input  logic                   wr_dout,
    input  logic [NUM_SENSORS-1:0] en_bits,
    input  logic                   clk_bit,
    input  logic                   dout_bit,
    output logic [NUM_SENSORS-1:0] en_q,
    output logic                   clk_q,
    output logic                   dout_q,
    output logic                   oe
);
    logic pending_q;

    // Purpose: per-sensor enables follow control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_ctrl) en_q <= en_bits;
    end

    // Purpose: shared clock level follows control writes, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n)       clk_q <= 1'b1;
        else if (wr_ctrl) clk_q <= clk_bit;
    end

    // Purpose: shared data-out level follows data-out writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= 1'b0;
        else if (wr_dout) dout_q <= dout_bit;
    end

    // Purpose: data pending from a data write until all sensors disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pending_q <= 1'b0;
        else if (wr_dout)                  pending_q <= 1'b1;
        else if (wr_ctrl && en_bits == '0) pending_q <= 1'b0;
    end

    // Purpose: drive the shared line only with pending data and a listener.
    always_comb oe = pending_q && (en_q != '0);
endmodule

// File: rtl/tsb_read_mux.sv
// Module: tsb_read_mux
// Registered read port: returns packed sensor data on the data-in
// address and zero everywhere else.
// Assumes: DATA_W >= NUM_SENSORS.
module tsb_read_mux #(
    parameter int unsigned NUM_SENSORS = 3,
    parameter int unsigned DATA_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_din,
    input  logic [NUM_SENSORS-1:0] sns_sync,
    output logic [DATA_W-1:0]      rdata
);
    localparam int unsigned PAD_W = DATA_W - NUM_SENSORS;

    logic [DATA_W-1:0] packed_din;

    // Purpose: zero-extend the sensor bits to bus width.
    always_comb begin
        if (PAD_W == 0) packed_din = DATA_W'(sns_sync);
        else            packed_din = {{PAD_W{1'b0}}, sns_sync};
    end

    // Purpose: one-cycle registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (sel_din) rdata <= packed_din;
        else              rdata <= '0;
    end
endmodule

// File: rtl/tsense_bridge.sv
// Module: tsense_bridge (top)
// Register-bus bridge that bit-bangs up to four three-wire temperature
// sensors: per-sensor enables, one shared clock, one shared data-out
// line with output enable, and a parallel read of every sensor's output.
// Assumes: 1 <= NUM_SENSORS <= 4, DATA_W >= 5, single-cycle bus access.
module tsense_bridge #(
    parameter int unsigned NUM_SENSORS = 3,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic [NUM_SENSORS-1:0] sns_en_o,
    output logic                   sns_clk_o,
    output logic                   sns_dq_o,
    output logic                   sns_dq_oe,
    input  logic [NUM_SENSORS-1:0] sns_dq_i
);
    import tsb_pkg::*;

    logic                   hit_ctrl, hit_dout, hit_din;
    logic                   wr_ctrl, wr_dout, rd_din;
    logic [NUM_SENSORS-1:0] din_sync;
    logic                   wdata_unused;

    // Purpose: address decode and strobe qualification.
    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
        hit_dout = (bus_addr == ADDR_W'(ADR_DOUT));
        hit_din  = (bus_addr == ADDR_W'(ADR_DIN));
        wr_ctrl  = bus_we && hit_ctrl;
        wr_dout  = bus_we && hit_dout;
        rd_din   = !bus_we && hit_din;
    end

    assign wdata_unused = ^bus_wdata;

    tsb_ctrl_regs #(.NUM_SENSORS(NUM_SENSORS)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_dout  (wr_dout),
        .en_bits  (bus_wdata[NUM_SENSORS-1:0]),
        .clk_bit  (bus_wdata[CLK_BIT]),
        .dout_bit (bus_wdata[0]),
        .en_q     (sns_en_o),
        .clk_q    (sns_clk_o),
        .dout_q   (sns_dq_o),
        .oe       (sns_dq_oe)
    );

    tsb_sync #(.WIDTH(NUM_SENSORS)) i_sync (
        .clk     (clk),
        .async_i (sns_dq_i),
        .sync_o  (din_sync)
    );

    tsb_read_mux #(.NUM_SENSORS(NUM_SENSORS), .DATA_W(DATA_W)) i_rmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_din  (rd_din),
        .sns_sync (din_sync),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/tsense_bridge_chk.sv
// Module: tsense_bridge_chk
// Property checker for tsense_bridge, bound to every instance.
// Assumes: reset is held for at least one rising edge at start.
module tsense_bridge_chk #(
    parameter int unsigned NUM_SENSORS = 3,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [NUM_SENSORS-1:0] sns_en_o,
    input logic                   sns_clk_o,
    input logic                   sns_dq_o,
    input logic                   sns_dq_oe,
    input logic [NUM_SENSORS-1:0] sns_dq_i
);
    import tsb_pkg::*;

    logic c_wctrl, c_wdout, c_rdin;
    assign c_wctrl = bus_we && bus_addr == ADDR_W'(ADR_CTRL);
    assign c_wdout = bus_we && bus_addr == ADDR_W'(ADR_DOUT);
    assign c_rdin  = !bus_we && bus_addr == ADDR_W'(ADR_DIN);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sns_en_o == '0 && sns_clk_o && !sns_dq_o && !sns_dq_oe)); // R1
    AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        c_wctrl |=> sns_en_o == $past(bus_wdata[NUM_SENSORS-1:0])); // R2
    AST_CLK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        c_wctrl |=> sns_clk_o == $past(bus_wdata[CLK_BIT])); // R3
    AST_CLK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !c_wctrl |=> $stable(sns_clk_o)); // R3
    AST_DQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        c_wdout |=> sns_dq_o == $past(bus_wdata[0])); // R5
    AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sns_dq_oe |-> sns_en_o != '0); // R6
    AST_OE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wdout && $past(rst_n)) |=> (sns_dq_oe == (sns_en_o != '0))); // R6
    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata >> NUM_SENSORS) == '0); // R7
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rdin && $past(rst_n)) |=> bus_rdata[NUM_SENSORS-1:0] == $past(sns_dq_i, 3)); // R8
    AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !c_rdin |=> bus_rdata == '0); // R9
endmodule

bind tsense_bridge tsense_bridge_chk #(
    .NUM_SENSORS(NUM_SENSORS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sns_en_o(sns_en_o),
    .sns_clk_o(sns_clk_o), .sns_dq_o(sns_dq_o), .sns_dq_oe(sns_dq_oe),
    .sns_dq_i(sns_dq_i)
);

// File: tb/test_tsense_bridge.sv
// Bench for tsense_bridge with three sensors.
module test_tsense_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [NS-1:0] sns_en_o;
    logic          sns_clk_o, sns_dq_o, sns_dq_oe;
    logic [NS-1:0] sns_dq_i = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsense_bridge #(.NUM_SENSORS(NS), .ADDR_W(4), .DATA_W(8)) i_tsense_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sns_en_o(sns_en_o),
        .sns_clk_o(sns_clk_o), .sns_dq_o(sns_dq_o), .sns_dq_oe(sns_dq_oe),
        .sns_dq_i(sns_dq_i)
    );

    // Vector: {addr[4], wdata[8], exp_en[3], exp_clk, exp_dq, exp_oe}
    localparam logic [17:0] VECS [NV] = '{
        {4'h0, 8'h05, 3'b101, 1'b0, 1'b0, 1'b0},
        {4'h1, 8'h01, 3'b101, 1'b0, 1'b1, 1'b1},
        {4'h0, 8'h15, 3'b101, 1'b1, 1'b1, 1'b1},
        {4'h1, 8'hFE, 3'b101, 1'b1, 1'b0, 1'b1},
        {4'h0, 8'h02, 3'b010, 1'b0, 1'b0, 1'b1},
        {4'h0, 8'h08, 3'b000, 1'b0, 1'b0, 1'b0},
        {4'h0, 8'h07, 3'b111, 1'b0, 1'b0, 1'b0},
        {4'h2, 8'hFF, 3'b111, 1'b0, 1'b0, 1'b0},
        {4'h9, 8'h1F, 3'b111, 1'b0, 1'b0, 1'b0},
        {4'h1, 8'h03, 3'b111, 1'b0, 1'b1, 1'b1}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R2";
            1: return "R5 R6";
            2: return "R3";
            3: return "R5";
            4: return "R2 R3";
            5: return "R4 R6";
            6: return "R6";
            7: return "R9";
            8: return "R10";
            default: return "R5 R6";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] pins();
        return {sns_en_o, sns_clk_o, sns_dq_o, sns_dq_oe};
    endfunction

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check(pins() == 6'b000_1_0_0, "R1 reset pins", 32'(pins()), 32'b000100);
        check(bus_rdata == 8'h00, "R1 reset rdata", 32'(bus_rdata), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(pins() == 6'b000_1_0_0, "R1 idle after reset", 32'(pins()), 32'b000100);

        // Table walk: one write per vector, pins checked one edge later.
        for (int i = 0; i < NV; i++) begin
            bus_addr  = VECS[i][17:14];
            bus_wdata = VECS[i][13:6];
            bus_we    = 1'b1;
            @(negedge clk);
            bus_we    = 1'b0;
            bus_addr  = 4'h5;
            check(pins() == VECS[i][5:0], vec_tag(i), 32'(pins()), 32'(VECS[i][5:0]));
        end

        // R8 / R7: synchronizer latency, read address held.
        bus_addr = 4'h2;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(bus_rdata == 8'h00, "R7 idle read", 32'(bus_rdata), 0);
        sns_dq_i = 3'b101;
        @(negedge clk);
        check(bus_rdata == 8'h00, "R8 after 1 edge", 32'(bus_rdata), 0);
        @(negedge clk);
        check(bus_rdata == 8'h00, "R8 after 2 edges", 32'(bus_rdata), 0);
        @(negedge clk);
        check(bus_rdata == 8'h05, "R8 after 3 edges", 32'(bus_rdata), 5);
        sns_dq_i = 3'b111;
        repeat (3) @(negedge clk);
        check(bus_rdata == 8'h07, "R7 all sensors, upper zero", 32'(bus_rdata), 7);

        // R9: reads of write-only registers return zero, pins untouched.
        bus_addr = 4'h0;
        @(negedge clk);
        check(bus_rdata == 8'h00, "R9 read ctrl", 32'(bus_rdata), 0);
        bus_addr = 4'h1;
        @(negedge clk);
        check(bus_rdata == 8'h00, "R9 read dout", 32'(bus_rdata), 0);
        check(pins() == 6'b111_0_1_1, "R9 pins after reads", 32'(pins()), 32'b111011);

        // R1: reset in mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        check(pins() == 6'b000_1_0_0, "R1 mid-run reset", 32'(pins()), 32'b000100);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule